// File: doc/BRIEF.md
# Edge Timestamp Capture Timer

This block is a free-running counter that records when edges arrive on a single capture pin. The counter steps once per clock from zero up to a programmable terminal value and then returns to zero. When a qualifying edge is seen on the capture pin, the counter value for that cycle goes into a four-entry first-in first-out store. The recorded time therefore does not depend on how quickly software responds. Software reads the stored stamps later and computes edge-to-edge intervals modulo (terminal value + 1). This allows for one counter wrap between two stamps. Resolution is one clock period: 24 MHz gives about 41.7 ns and 1 MHz gives 1 µs.

A programmable group size N sets when the interrupt line rises: after every N qualifying edges, so one service call handles a whole group of stamps. The interrupt and an overflow indication stay set until software clears them with single-cycle strobes. Reads use a pop strobe, with registered data, an occupancy level and empty and full flags.

Top module: `edge_stamp_timer`

## Requirements
- R1: The counter starts at 0 after reset, steps by one each clock while below `cfg_period`, and returns to 0 on the cycle after it equals (or exceeds) `cfg_period`, so every stamp lies in 0..`cfg_period`.
- R2: `cap_in` passes through a two-flop synchronizer. The stamp stored is the counter value on the cycle the edge is detected, so two stamps differ by exactly the number of clocks between the two input transitions, modulo `cfg_period`+1. A stamp is in the store, and its effects appear at the outputs, on the third rising clock edge after the input changes.
- R3: `cfg_mode` selects the qualifying edge: 2'b00 rising only, 2'b01 falling only, 2'b10 both edges, 2'b11 no captures.
- R4: The store holds 4 stamps in arrival order. A one-cycle `rd_pop` makes `rd_data` show the oldest stamp from the next clock, and that stamp is removed.
- R5: A pop while the store is empty sets `rd_data` to 0 and leaves the level and flags unchanged.
- R6: `fifo_level` gives the number of stored stamps (0..4); `fifo_empty` is high at level 0 and `fifo_full` is high at level 4.
- R7: A capture that arrives while the store is full and no pop is pending is discarded, and `overflow` goes high. `overflow` stays high until an `ovf_clr` strobe; if a new discard happens in the same cycle as the strobe, the discard wins.
- R8: `irq` rises together with the N-th qualifying edge, where N is `cfg_per_irq` (1..4; 0 acts as 1). The edge count restarts at zero when `irq` is raised. Discarded captures still count.
- R9: `irq` stays high until an `irq_clr` strobe lowers it on the next clock; if a new raise happens in the same cycle as the strobe, the raise wins.
- R10: Synchronous active-high `rst` clears the counter, the store, `rd_data`, the edge count, `irq` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timestamp tick |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture pin |
| cfg_period | input | CNT_W | Terminal count; the counter spans 0..cfg_period |
| cfg_mode | input | 2 | Qualifying-edge select (see R3) |
| cfg_per_irq | input | N_W | Captures per interrupt, 1..4 |
| rd_pop | input | 1 | Pop strobe for the oldest stamp |
| irq_clr | input | 1 | Clears the interrupt |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | CNT_W | Registered popped stamp, 0 after a pop on empty |
| fifo_empty | output | 1 | Store holds no stamps |
| fifo_full | output | 1 | Store holds 4 stamps |
| fifo_level | output | LVL_W | Number of stored stamps |
| overflow | output | 1 | Sticky discard flag |
| irq | output | 1 | Interrupt request, held until cleared |

## Verification
A change on `cap_in` takes three rising clock edges to show at the outputs: two synchronizer stages, then the detect-and-store edge. The bench drives every input on a falling edge and samples on later falling edges. Its interrupt check looks two falling edges after the toggle and expects `irq` still low, then looks one falling edge later and expects it high. A pop or clear strobe takes effect one clock later, so popped data and cleared flags are sampled at the next falling edge. Intervals are checked as differences between stamps, computed modulo the period. The expected values come only from how many falling edges the bench waited between toggles.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  typedef enum logic [1:0] {
    CAP_RISE = 2'b00,
    CAP_FALL = 2'b01,
    CAP_BOTH = 2'b10,
    CAP_OFF  = 2'b11
  } cap_mode_e;
endpackage

// File: rtl/es_period_counter.sv
module es_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (count >= period) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/es_edge_detect.sv
module es_edge_detect
  import edge_stamp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sig_in,
  input  cap_mode_e mode,
  output logic      cap_stb
);
  logic sync_a, sync_b, prev_b;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      sync_a <= sig_in;
      sync_b <= sync_a;
      prev_b <= sync_b;
    end
  end

  assign rise = sync_b & ~prev_b;
  assign fall = ~sync_b & prev_b;

  always_comb begin
    case (mode)
      CAP_RISE: cap_stb = rise;
      CAP_FALL: cap_stb = fall;
      CAP_BOTH: cap_stb = rise | fall;
      default:  cap_stb = 1'b0;
    endcase
  end
endmodule

// File: rtl/es_capture_fifo.sv
module es_capture_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [W-1:0]   push_data,
  input  logic           pop,
  output logic [W-1:0]   rd_data,
  output logic           empty,
  output logic           full,
  output logic [PTR_W:0] level,
  output logic           drop
);
  logic [W-1:0]   mem [DEPTH];
  logic [PTR_W:0] wr_ptr, rd_ptr;
  logic           push_ok, pop_ok;

  assign level   = wr_ptr - rd_ptr;
  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                   (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign drop    = push & full & ~pop_ok;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        if (pop_ok) begin
          rd_data <= mem[rd_ptr[PTR_W-1:0]];
          rd_ptr  <= rd_ptr + 1'b1;
        end else begin
          rd_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/es_irq_gen.sv
module es_irq_gen #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb,
  input  logic [N_W-1:0] per_irq,
  input  logic           clr,
  output logic           irq
);
  logic [N_W-1:0] evt_q;
  logic [N_W-1:0] eff_n;
  logic [N_W:0]   evt_next;
  logic           fire;

  assign eff_n    = (per_irq == '0) ? N_W'(1) : per_irq;
  assign evt_next = {1'b0, evt_q} + 1'b1;
  assign fire     = stb && (evt_next >= {1'b0, eff_n});

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (stb) evt_q <= fire ? '0 : evt_next[N_W-1:0];
      if (fire)     irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH) + 1,
  parameter int N_W        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [1:0]       cfg_mode,
  input  logic [N_W-1:0]   cfg_per_irq,
  input  logic             rd_pop,
  input  logic             irq_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] rd_data,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic [LVL_W-1:0] fifo_level,
  output logic             overflow,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             cap_stb;
  logic             drop;
  cap_mode_e        mode_e;

  assign mode_e = cap_mode_e'(cfg_mode);

  es_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .period(cfg_period), .count(cnt_q)
  );

  es_edge_detect u_edge (
    .clk(clk), .rst(rst), .sig_in(cap_in), .mode(mode_e), .cap_stb(cap_stb)
  );

  es_capture_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(cap_stb), .push_data(cnt_q), .pop(rd_pop),
    .rd_data(rd_data), .empty(fifo_empty), .full(fifo_full),
    .level(fifo_level), .drop(drop)
  );

  es_irq_gen #(.N_W(N_W)) u_irq (
    .clk(clk), .rst(rst), .stb(cap_stb), .per_irq(cfg_per_irq),
    .clr(irq_clr), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)          overflow <= 1'b0;
    else if (drop)    overflow <= 1'b1;
    else if (ovf_clr) overflow <= 1'b0;
  end
endmodule

// File: rtl/edge_stamp_timer_chk.sv
module edge_stamp_timer_chk #(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_period,
  input logic [1:0]       cfg_mode,
  input logic             rd_pop,
  input logic             irq_clr,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cap_stb,
  input logic [CNT_W-1:0] rd_data,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level,
  input logic             overflow,
  input logic             irq
);
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= cfg_period) |=> (cnt_q == '0));

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < cfg_period) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_mode_off_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b11) |-> !cap_stb);

  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && rd_pop && !cap_stb) |=> (rd_data == '0) && fifo_empty);

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_level <= LVL_W'(FIFO_DEPTH)) && (fifo_full == (fifo_level == LVL_W'(FIFO_DEPTH))));

  assert_drop_full_R7: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && cap_stb && !rd_pop) |=> overflow && fifo_full);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

bind edge_stamp_timer edge_stamp_timer_chk #(
  .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_mode(cfg_mode),
  .rd_pop(rd_pop), .irq_clr(irq_clr), .ovf_clr(ovf_clr), .cnt_q(cnt_q),
  .cap_stb(cap_stb), .rd_data(rd_data), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .fifo_level(fifo_level), .overflow(overflow),
  .irq(irq)
);

// File: tb/edge_stamp_timer_bench.sv
module edge_stamp_timer_bench;
  localparam int CNT_W = 16;
  localparam int N_W   = 3;
  localparam int LVL_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cap_in = 1'b0;
  logic [CNT_W-1:0] cfg_period = 16'd1000;
  logic [1:0]       cfg_mode = 2'b00;
  logic [N_W-1:0]   cfg_per_irq = 3'd4;
  logic             rd_pop = 1'b0;
  logic             irq_clr = 1'b0;
  logic             ovf_clr = 1'b0;
  logic [CNT_W-1:0] rd_data;
  logic             fifo_empty, fifo_full, overflow, irq;
  logic [LVL_W-1:0] fifo_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  edge_stamp_timer u_edge_stamp_timer (
    .clk(clk), .rst(rst), .cap_in(cap_in), .cfg_period(cfg_period),
    .cfg_mode(cfg_mode), .cfg_per_irq(cfg_per_irq), .rd_pop(rd_pop),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level),
    .overflow(overflow), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint moddiff(input longint b, input longint a,
                                     input longint p);
    return (b >= a) ? (b - a) : (b + p + 1 - a);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cap(input logic v, input int gap);
    cap_in = v;
    wait_n(gap);
  endtask

  task automatic pop_one(output logic [CNT_W-1:0] v);
    rd_pop = 1'b1;
    wait_n(1);
    rd_pop = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cap_in = 1'b0;
    rd_pop = 1'b0;
    irq_clr = 1'b0;
    ovf_clr = 1'b0;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10", "empty after reset", fifo_empty, 1);
    check("R10", "level after reset", fifo_level, 0);
    check("R10", "irq after reset", irq, 0);
    check("R10", "overflow after reset", overflow, 0);
    check("R10", "rd_data after reset", rd_data, 0);
  endtask

  task automatic t_interval();
    logic [CNT_W-1:0] a, b, c, z;
    cfg_period = 16'd1000; cfg_mode = 2'b00; cfg_per_irq = 3'd4;
    do_reset();
    set_cap(1, 10); set_cap(0, 27);
    set_cap(1, 10); set_cap(0, 42);
    set_cap(1, 10); set_cap(0, 5);
    check("R6", "level after three rises", fifo_level, 3);
    check("R6", "empty with data", fifo_empty, 0);
    check("R8", "no irq below group size", irq, 0);
    pop_one(a); pop_one(b); pop_one(c);
    check("R2", "interval one", moddiff(b, a, 1000), 37);
    check("R4", "interval two in order", moddiff(c, b, 1000), 52);
    check("R6", "empty after draining", fifo_empty, 1);
    pop_one(z);
    check("R5", "pop on empty data", z, 0);
    check("R5", "pop on empty level", fifo_level, 0);
  endtask

  task automatic t_modes();
    logic [CNT_W-1:0] a, b;
    cfg_mode = 2'b01;
    do_reset();
    set_cap(1, 5); set_cap(0, 31); set_cap(1, 5); set_cap(0, 8);
    check("R3", "falling mode count", fifo_level, 2);
    pop_one(a); pop_one(b);
    check("R3", "falling mode interval", moddiff(b, a, 1000), 36);
    cfg_mode = 2'b10;
    do_reset();
    set_cap(1, 23); set_cap(0, 8);
    check("R3", "both mode count", fifo_level, 2);
    pop_one(a); pop_one(b);
    check("R3", "both mode pulse width", moddiff(b, a, 1000), 23);
    cfg_mode = 2'b11;
    do_reset();
    set_cap(1, 9); set_cap(0, 9); set_cap(1, 9); set_cap(0, 9);
    check("R3", "disabled mode empty", fifo_empty, 1);
    check("R3", "disabled mode irq", irq, 0);
    cfg_mode = 2'b00;
  endtask

  task automatic t_wrap();
    logic [CNT_W-1:0] a, b;
    cfg_period = 16'd9; cfg_mode = 2'b00;
    do_reset();
    set_cap(1, 5); set_cap(0, 10); set_cap(1, 5); set_cap(0, 6);
    pop_one(a); pop_one(b);
    check("R1", "first stamp in range", (a <= 9), 1);
    check("R1", "second stamp in range", (b <= 9), 1);
    check("R1", "wrapped interval", moddiff(b, a, 9), 5);
    cfg_period = 16'd1000;
  endtask

  task automatic t_irq();
    cfg_mode = 2'b00; cfg_per_irq = 3'd2;
    do_reset();
    set_cap(1, 5); set_cap(0, 6);
    check("R8", "one of two edges", irq, 0);
    set_cap(1, 2);
    check("R2", "irq not before third edge", irq, 0);
    wait_n(1);
    check("R8", "irq on second edge", irq, 1);
    set_cap(0, 10);
    check("R9", "irq held", irq, 1);
    irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0;
    check("R9", "irq cleared", irq, 0);
    set_cap(1, 5); set_cap(0, 6);
    check("R8", "count restarted", irq, 0);
    set_cap(1, 5); set_cap(0, 6);
    check("R8", "second group fires", irq, 1);
    irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0;
    cfg_per_irq = 3'd1;
    set_cap(1, 5); set_cap(0, 6);
    check("R8", "group of one fires", irq, 1);
    do_reset();
    check("R10", "reset clears irq", irq, 0);
    check("R10", "reset clears store", fifo_empty, 1);
  endtask

  task automatic t_overflow();
    logic [CNT_W-1:0] v [4];
    cfg_mode = 2'b00; cfg_per_irq = 3'd4;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      set_cap(1, 6); set_cap(0, 6);
    end
    check("R6", "full at four", fifo_full, 1);
    check("R6", "level four", fifo_level, 4);
    check("R7", "no overflow yet", overflow, 0);
    set_cap(1, 6); set_cap(0, 6);
    check("R7", "overflow on fifth", overflow, 1);
    check("R7", "level held at four", fifo_level, 4);
    for (int i = 0; i < 4; i++) pop_one(v[i]);
    for (int i = 1; i < 4; i++)
      check("R7", "kept oldest stamps", moddiff(v[i], v[i-1], 1000), 12);
    check("R7", "overflow still set", overflow, 1);
    ovf_clr = 1'b1; wait_n(1); ovf_clr = 1'b0;
    check("R7", "overflow cleared", overflow, 0);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_modes();
    t_wrap();
    t_irq();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule